// File: doc/BRIEF.md
# Configurable Slice Order Reverser

This block takes one data word at a time and rearranges it as a list of equal-sized slices. A run-time size code picks the slice size from 1, 2, 4, 8 or 16 bits. A mode input picks between two behaviours:

- **Reverse:** the slice order is reversed.
- **Pass:** the word goes through untouched.

Bits inside a slice always keep their order. The word width is a parameter. When the slice size does not divide the width, a shorter leftover slice is moved whole, with no padding. A slice size of 1 therefore gives a full bit reversal. A slice size of 8 gives a byte swap.

The input is a word qualified by a valid strobe. The result is registered and leaves one clock later with its own valid. Because the input and output formats match, instances can be chained to build compound reorderings. For example, a bit reversal followed by a pair swap.

Top module: `slice_reverser`

## Requirements
- R1: In reverse mode (`rev_en`=1), slice k is `in_data[k*S +: S]` for k = 0 .. N-1, where S is the slice size and N = floor(WIDTH/S). Slice k appears at `out_data[WIDTH-1-k*S -: S]`, with the bit order inside the slice kept. On a 32-bit word whose bytes from the top are A,B,C,D, S=8 gives D,C,B,A and S=16 gives C,D,A,B.
- R2: In pass mode (`rev_en`=0), `out_data` equals the accepted `in_data` for every size code.
- R3: `size_code` values 0,1,2,3,4 select S = 1,2,4,8,16 bits. Codes 5, 6 and 7 leave the word unchanged even in reverse mode.
- R4: When WIDTH is not a multiple of S, the R = WIDTH - N*S most-significant input bits form a short remnant. The remnant is placed unpadded at `out_data[R-1:0]`. For WIDTH=6 and S=4, 6'b110101 becomes 6'b010111.
- R5: A slice size larger than WIDTH leaves the word unchanged.
- R6: `out_valid` is high in the cycle after `in_valid` was high, and low in the cycle after `in_valid` was low. The matching `out_data` appears in that same cycle.
- R7: While `in_valid` is low, `out_data` holds its last value.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero.
- R9: S=1 gives a full bit reversal, so 8'b0011_0101 becomes 8'b1010_1100.
- R10: Two chained instances compose. With WIDTH=4, a full bit reversal followed by a 2-bit slice reversal turns 4'b1101 into 4'b1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | WIDTH | Input word |
| rev_en | input | 1 | 1 = reverse slices, 0 = pass through |
| size_code | input | 3 | Slice size select (0..4 gives 1,2,4,8,16 bits) |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | WIDTH | Registered rearranged word |

## Verification
The block is a fixed wire permutation followed by one register stage, so any wrong internal routing shows up as a wrong output word in the cycle right after the input is accepted. A mis-wired slice network shows up only for its own size code. A mishandled remnant shows up only at widths that the slice size does not divide. For that reason, every size code is swept in both modes, at a divisible width and at a 6-bit width. The 6-bit width is swept exhaustively. A bad valid path or hold enable shows up within one cycle as a wrong `out_valid` or a changed `out_data`.

// File: rtl/slice_rev_pkg.sv
package slice_rev_pkg;

  // Number of selectable slice sizes: 1, 2, 4, 8, 16 bits.
  localparam int NUM_SIZES = 5;
  localparam int CODE_W    = 3;

  typedef enum logic [CODE_W-1:0] {
    SZ_1  = 3'd0,
    SZ_2  = 3'd1,
    SZ_4  = 3'd2,
    SZ_8  = 3'd3,
    SZ_16 = 3'd4
  } size_code_e;

endpackage

// File: rtl/slice_swap_net.sv
// Fixed permutation for one slice size. Full slices are taken from the LSB end.
// A short top remnant lands at the LSB end of the result.
module slice_swap_net #(
  parameter int WIDTH = 32,
  parameter int SLICE = 8
) (
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] word_o
);

  localparam int NFULL = WIDTH / SLICE;
  localparam int REM   = WIDTH - NFULL * SLICE;

  genvar k;
  generate
    for (k = 0; k < NFULL; k++) begin : g_full
      assign word_o[WIDTH-1-k*SLICE -: SLICE] = word_i[k*SLICE +: SLICE];
    end
    if (REM > 0) begin : g_rem
      assign word_o[REM-1:0] = word_i[WIDTH-1 -: REM];
    end
  endgenerate

endmodule

// File: rtl/slice_select.sv
// Builds one swap network per size and picks one by code.
// Out-of-range codes pass the word through.
module slice_select
  import slice_rev_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]  word_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [WIDTH-1:0]  word_o
);

  logic [WIDTH-1:0] cand [NUM_SIZES];

  genvar g;
  generate
    for (g = 0; g < NUM_SIZES; g++) begin : g_net
      slice_swap_net #(
        .WIDTH (WIDTH),
        .SLICE (1 << g)
      ) u_net (
        .word_i (word_i),
        .word_o (cand[g])
      );
    end
  endgenerate

  always_comb begin
    word_o = word_i;
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (code_i == i[CODE_W-1:0]) word_o = cand[i];
    end
  end

endmodule

// File: rtl/slice_reverser.sv
module slice_reverser
  import slice_rev_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WIDTH-1:0]  in_data,
  input  logic              rev_en,
  input  logic [CODE_W-1:0] size_code,
  output logic              out_valid,
  output logic [WIDTH-1:0]  out_data
);

  logic [WIDTH-1:0] swapped;

  slice_select #(.WIDTH(WIDTH)) u_sel (
    .word_i (in_data),
    .code_i (size_code),
    .word_o (swapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= rev_en ? swapped : in_data;
    end
  end

  // R6: valid follows the input strobe by one cycle
  a_r6_valid_lat: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R7: data held while idle
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  // R2: pass mode is transparent
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !rev_en) |=> (out_data == $past(in_data)));
  // R1: any reordering is a permutation, so the count of ones is preserved
  a_r1_perm: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($countones(out_data) == $countones($past(in_data))));

endmodule

// File: tb/sim_slice_reverser.sv
`timescale 1ns/1ps
module sim_slice_reverser;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        v = 1'b0, rev = 1'b0;
  logic [2:0]  code = 3'd0;
  logic [31:0] d32 = '0;
  logic [5:0]  d6 = '0;
  logic [7:0]  d8 = '0;
  logic [3:0]  d4 = '0;
  logic        ov32, ov6, ov8, ov4a, ov4b;
  logic [31:0] o32;
  logic [5:0]  o6;
  logic [7:0]  o8;
  logic [3:0]  o4a, o4b;

  slice_reverser #(.WIDTH(32)) u0 (.clk(clk), .rst(rst), .in_valid(v), .in_data(d32),
    .rev_en(rev), .size_code(code), .out_valid(ov32), .out_data(o32));
  slice_reverser #(.WIDTH(6)) u1 (.clk(clk), .rst(rst), .in_valid(v), .in_data(d6),
    .rev_en(rev), .size_code(code), .out_valid(ov6), .out_data(o6));
  slice_reverser #(.WIDTH(8)) u2 (.clk(clk), .rst(rst), .in_valid(v), .in_data(d8),
    .rev_en(1'b1), .size_code(3'd0), .out_valid(ov8), .out_data(o8));
  slice_reverser #(.WIDTH(4)) u3 (.clk(clk), .rst(rst), .in_valid(v), .in_data(d4),
    .rev_en(1'b1), .size_code(3'd0), .out_valid(ov4a), .out_data(o4a));
  slice_reverser #(.WIDTH(4)) u4 (.clk(clk), .rst(rst), .in_valid(ov4a), .in_data(o4a),
    .rev_en(1'b1), .size_code(3'd1), .out_valid(ov4b), .out_data(o4b));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected word computed bit by bit from the slice arithmetic.
  function automatic logic [31:0] model(input logic [31:0] d, input int w,
                                        input int c, input logic r);
    logic [31:0] res;
    int s, nf, dst;
    if (!r || c > 4) return d;
    s = 1 << c;
    nf = w / s;
    res = '0;
    for (int i = 0; i < w; i++) begin
      if (i < nf * s) dst = w - (i / s + 1) * s + (i % s);
      else            dst = i - nf * s;
      res[dst] = d[i];
    end
    return res;
  endfunction

  task automatic apply(input logic [31:0] a, input logic [5:0] b, input logic r,
                       input logic [2:0] c);
    @(negedge clk);
    d32 = a; d6 = b; rev = r; code = c; v = 1'b1;
    @(negedge clk);
    v = 1'b0;
  endtask

  initial begin : watchdog
    #900000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 valid", {31'b0, ov32}, 32'd0);
    chk("R8 data", o32, 32'd0);
    rst = 1'b0;

    // R1: byte and half-word reversal on A,B,C,D
    apply(32'h41424344, 6'd0, 1'b1, 3'd3);
    chk("R1 byte", o32, 32'h44434241);
    chk("R6 valid", {31'b0, ov32}, 32'd1);
    apply(32'h41424344, 6'd0, 1'b1, 3'd4);
    chk("R1 half", o32, 32'h43444142);

    // R4: remnant example
    apply(32'd0, 6'b110101, 1'b1, 3'd2);
    chk("R4 remnant", {26'b0, o6}, {26'b0, 6'b010111});
    // R5: 8- and 16-bit slices exceed the 6-bit width
    apply(32'd0, 6'b101100, 1'b1, 3'd3);
    chk("R5 oversize8", {26'b0, o6}, {26'b0, 6'b101100});
    apply(32'd0, 6'b011001, 1'b1, 3'd4);
    chk("R5 oversize16", {26'b0, o6}, {26'b0, 6'b011001});
    // R3: out-of-range code passes the word through
    apply(32'h12345678, 6'd0, 1'b1, 3'd6);
    chk("R3 code6", o32, 32'h12345678);

    // R7: hold with a new word on the input while valid is low
    held = o32;
    @(negedge clk); d32 = 32'hFFFF0000;
    @(negedge clk);
    chk("R7 hold", o32, held);
    chk("R6 low", {31'b0, ov32}, 32'd0);

    // R9 bit reversal and R10 chain
    @(negedge clk); d8 = 8'b0011_0101; d4 = 4'b1101; v = 1'b1;
    @(negedge clk); v = 1'b0;
    chk("R9 bitrev", {24'b0, o8}, {24'b0, 8'b1010_1100});
    @(negedge clk);
    chk("R10 chain", {28'b0, o4b}, {28'b0, 4'b1110});

    // R1 R2 R3 R4: exhaustive 6-bit and random 32-bit sweeps, all codes, both modes
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int x = 0; x < 64; x++) begin
          w = $urandom;
          apply(w, x[5:0], m[0], c[2:0]);
          chk(m[0] ? "R1 sweep32" : "R2 sweep32", o32, model(w, 32, c, m[0]));
          chk(m[0] ? "R4 sweep6" : "R2 sweep6", {26'b0, o6},
              model({26'b0, x[5:0]}, 6, c, m[0]));
        end
      end
    end

    // R8: reset clears again after traffic
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R8 reclear", o32, 32'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule